// File: doc/BRIEF.md
# Surface Descriptor Table

This block holds a table of memory surface descriptors. Each descriptor gives a base address, a line width, a height, a wrap mode, a block mode and, in one build variant, an endianness code. Base and width are counted in 8-byte units, so software rounds its byte values up before loading them. Software reaches the table only indirectly, through three 32-bit registers on a simple register bus. It loads a descriptor into two staging registers, then writes a command word. The command names an entry index and asks either to commit the staged descriptor into that entry or to fetch the entry back into the staging registers.

The width field is split across the two staging registers. Its three low bits sit at the top of the low word and the rest at the bottom of the high word. A separate lookup port serves a display or memory client: the client presents an index and receives the full decoded descriptor one clock later.

The parameter `HAS_ENDIAN` selects the build variant. With it cleared, the endianness field is never stored and always reads as zero.

Top module: `surf_desc_table`

## Requirements
- R1: After reset, both staging registers, the command readback, every table entry and the lookup output are all zero.
- R2: A write to offset 0x00 loads the low staging word, which is then read back unchanged. In that word, bits 28:0 hold the base address and bits 31:29 hold width bits 2:0.
- R3: A write to offset 0x04 loads the high staging word. Its fields are width bits 11:3 in bits 8:0, height in 21:9, wrap in 23:22, block mode in 25:24 and endianness in 29:26. Bits 31:30 always read zero.
- R4: A write to offset 0x08 with bit 9 set commits both staging words into the entry indexed by bits 7:0. The entry holds the new value from the clock edge that accepts the write, so a lookup of that index presented in the next cycle returns it. Reading offset 0x08 returns the last written index in bits 7:0 and zero above.
- R5: A write to offset 0x08 with bit 8 set and bit 9 clear fetches the indexed entry into both staging words. The load happens at the edge one cycle after the accepting edge; until then the staging words keep their old values.
- R6: When bits 8 and 9 are both set, only the commit takes place and the staging words are not reloaded.
- R7: A fetch landing in the same cycle as a bus write to a staging word overrides that write.
- R8: The lookup output shows the descriptor at `lk_idx` one clock after the index is presented. It reflects the table as it stood before any commit accepted at that same edge.
- R9: With `HAS_ENDIAN` = 0, bits 29:26 of the high staging word read zero and the lookup endianness output stays zero, whatever was written.
- R10: Writes to any offset other than 0x00, 0x04 or 0x08 change nothing, and reads from such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lk_idx | input | IDX_W (8) | Lookup index |
| lk_base | output | 29 | Looked-up base address, 8-byte units |
| lk_width | output | 12 | Looked-up line width, 8-byte units |
| lk_height | output | 13 | Looked-up height |
| lk_wrap | output | 2 | Looked-up wrap mode |
| lk_blk | output | 2 | Looked-up block mode |
| lk_endian | output | 4 | Looked-up endianness code |

## Verification
Read data depends only on the current address and the staging state, so the bench compares it a quarter period after it drives the address, in the same cycle. A commit changes the table at the accepting edge. A fetch reaches the staging words one edge later, so the bench expects the old staging values in the cycle between the two edges. Lookup results belong to the edge after the index is presented and are compared just after the following falling edge. A behavioural model steps at each rising edge using the inputs that were held for that edge, and it covers both build variants side by side.

// File: rtl/surf_desc_pkg.sv
package surf_desc_pkg;

    localparam int WORD_W    = 32;
    localparam int BASE_W    = 29;
    localparam int WID_LO_W  = 3;
    localparam int WID_HI_W  = 9;
    localparam int WID_W     = WID_LO_W + WID_HI_W;
    localparam int HGT_W     = 13;
    localparam int WRAP_W    = 2;
    localparam int BLK_W     = 2;
    localparam int END_W     = 4;

    localparam int HGT_LSB   = WID_HI_W;
    localparam int WRAP_LSB  = HGT_LSB + HGT_W;
    localparam int BLK_LSB   = WRAP_LSB + WRAP_W;
    localparam int END_LSB   = BLK_LSB + BLK_W;
    localparam int HI_USED_W = END_LSB + END_W;

    localparam int CMD_IDX_W  = 8;
    localparam int CMD_RD_BIT = 8;
    localparam int CMD_WR_BIT = 9;

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFS_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_HI  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CMD = 4'h8;

    typedef struct packed {
        logic [END_W-1:0]  endian;
        logic [BLK_W-1:0]  blk;
        logic [WRAP_W-1:0] wrap;
        logic [HGT_W-1:0]  height;
        logic [WID_W-1:0]  width;
        logic [BASE_W-1:0] base;
    } surf_desc_t;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_COMMIT = 2'd1,
        CMD_FETCH  = 2'd2
    } cmd_op_e;

    typedef struct packed {
        cmd_op_e              op;
        logic [CMD_IDX_W-1:0] idx;
    } cmd_t;

    function automatic logic [WORD_W-1:0] desc_lo_word(input surf_desc_t d);
        return {d.width[WID_LO_W-1:0], d.base};
    endfunction

    function automatic logic [WORD_W-1:0] desc_hi_word(input surf_desc_t d);
        return {{(WORD_W-HI_USED_W){1'b0}}, d.endian, d.blk, d.wrap,
                d.height, d.width[WID_W-1:WID_LO_W]};
    endfunction

    function automatic surf_desc_t desc_set_lo(input surf_desc_t d,
                                               input logic [WORD_W-1:0] w);
        surf_desc_t r;
        r = d;
        r.base = w[BASE_W-1:0];
        r.width[WID_LO_W-1:0] = w[WORD_W-1 -: WID_LO_W];
        return r;
    endfunction

    function automatic surf_desc_t desc_set_hi(input surf_desc_t d,
                                               input logic [WORD_W-1:0] w);
        surf_desc_t r;
        logic       unused_rsvd;
        r = d;
        r.width[WID_W-1:WID_LO_W] = w[WID_HI_W-1:0];
        r.height = w[HGT_LSB +: HGT_W];
        r.wrap   = w[WRAP_LSB +: WRAP_W];
        r.blk    = w[BLK_LSB +: BLK_W];
        r.endian = w[END_LSB +: END_W];
        unused_rsvd = ^w[WORD_W-1:HI_USED_W];
        return r;
    endfunction

endpackage

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
    import surf_desc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic                 wr_lo,
    output logic                 wr_hi,
    output logic                 commit,
    output logic [IDX_W-1:0]     commit_idx,
    output logic                 rb_load,
    output logic [IDX_W-1:0]     rb_idx,
    output logic [CMD_IDX_W-1:0] last_idx
);

    cmd_t                 cmd_c;
    logic                 cmd_wr;
    logic                 fetch_q;
    logic [IDX_W-1:0]     rb_idx_q;
    logic [CMD_IDX_W-1:0] last_q;
    logic                 unused_wdata_hi;

    assign cmd_wr = bus_we && (bus_addr == OFS_CMD);

    // Commit outranks fetch when both enables are present.
    always_comb begin
        cmd_c.idx = bus_wdata[CMD_IDX_W-1:0];
        cmd_c.op  = CMD_NONE;
        if (cmd_wr) begin
            if (bus_wdata[CMD_WR_BIT]) begin
                cmd_c.op = CMD_COMMIT;
            end else if (bus_wdata[CMD_RD_BIT]) begin
                cmd_c.op = CMD_FETCH;
            end
        end
    end

    assign wr_lo      = bus_we && (bus_addr == OFS_LO);
    assign wr_hi      = bus_we && (bus_addr == OFS_HI);
    assign commit     = (cmd_c.op == CMD_COMMIT);
    assign commit_idx = cmd_c.idx[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q  <= 1'b0;
            rb_idx_q <= '0;
            last_q   <= '0;
        end else begin
            fetch_q <= (cmd_c.op == CMD_FETCH);
            if (cmd_c.op == CMD_FETCH) begin
                rb_idx_q <= cmd_c.idx[IDX_W-1:0];
            end
            if (cmd_wr) begin
                last_q <= cmd_c.idx;
            end
        end
    end

    assign rb_load  = fetch_q;
    assign rb_idx   = rb_idx_q;
    assign last_idx = last_q;

    assign unused_wdata_hi = ^bus_wdata[WORD_W-1:CMD_WR_BIT+1];

endmodule

// File: rtl/sdt_staging.sv
module sdt_staging
    import surf_desc_pkg::*;
#(
    parameter bit HAS_ENDIAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rb_load,
    input  surf_desc_t        rb_desc,
    output surf_desc_t        stage
);

    surf_desc_t       stage_q;
    surf_desc_t       stage_d;
    surf_desc_t       hi_merged;
    logic [END_W-1:0] end_field;

    generate
        if (HAS_ENDIAN) begin : g_end_keep
            assign end_field = wdata[END_LSB +: END_W];
        end else begin : g_end_drop
            assign end_field = '0;
        end
    endgenerate

    always_comb begin
        hi_merged        = desc_set_hi(stage_q, wdata);
        hi_merged.endian = end_field;
        stage_d          = stage_q;
        // A landing fetch takes precedence over a bus write this cycle.
        if (rb_load) begin
            stage_d = rb_desc;
        end else if (wr_lo) begin
            stage_d = desc_set_lo(stage_q, wdata);
        end else if (wr_hi) begin
            stage_d = hi_merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign stage = stage_q;

endmodule

// File: rtl/sdt_store.sv
module sdt_store
    import surf_desc_pkg::*;
#(
    parameter int NUM_ENTRIES = 256,
    parameter int IDX_W       = 8,
    parameter bit HAS_ENDIAN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IDX_W-1:0] commit_idx,
    input  surf_desc_t       commit_desc,
    input  logic [IDX_W-1:0] rb_idx,
    output surf_desc_t       rb_desc,
    input  logic [IDX_W-1:0] lk_idx,
    output surf_desc_t       lk_desc
);

    surf_desc_t tbl_q [NUM_ENTRIES];
    surf_desc_t wr_val;
    surf_desc_t lk_q;

    generate
        if (HAS_ENDIAN) begin : g_store_end
            assign wr_val = commit_desc;
        end else begin : g_store_noend
            always_comb begin
                wr_val        = commit_desc;
                wr_val.endian = '0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tbl_q[i] <= '0;
            end
            lk_q <= '0;
        end else begin
            lk_q <= tbl_q[lk_idx];
            if (commit) begin
                tbl_q[commit_idx] <= wr_val;
            end
        end
    end

    assign rb_desc = tbl_q[rb_idx];
    assign lk_desc = lk_q;

endmodule

// File: rtl/surf_desc_table.sv
module surf_desc_table
    import surf_desc_pkg::*;
#(
    parameter int NUM_ENTRIES = 256,
    parameter bit HAS_ENDIAN  = 1'b1,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [BASE_W-1:0]  lk_base,
    output logic [WID_W-1:0]   lk_width,
    output logic [HGT_W-1:0]   lk_height,
    output logic [WRAP_W-1:0]  lk_wrap,
    output logic [BLK_W-1:0]   lk_blk,
    output logic [END_W-1:0]   lk_endian
);

    logic                 wr_lo;
    logic                 wr_hi;
    logic                 commit;
    logic [IDX_W-1:0]     commit_idx;
    logic                 rb_load;
    logic [IDX_W-1:0]     rb_idx;
    logic [CMD_IDX_W-1:0] last_idx;
    surf_desc_t           stage_q;
    surf_desc_t           rb_desc;
    surf_desc_t           lk_q;

    sdt_cmd_decode #(
        .IDX_W (IDX_W)
    ) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .commit     (commit),
        .commit_idx (commit_idx),
        .rb_load    (rb_load),
        .rb_idx     (rb_idx),
        .last_idx   (last_idx)
    );

    sdt_staging #(
        .HAS_ENDIAN (HAS_ENDIAN)
    ) u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (bus_wdata),
        .rb_load (rb_load),
        .rb_desc (rb_desc),
        .stage   (stage_q)
    );

    sdt_store #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W),
        .HAS_ENDIAN  (HAS_ENDIAN)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_desc (stage_q),
        .rb_idx      (rb_idx),
        .rb_desc     (rb_desc),
        .lk_idx      (lk_idx),
        .lk_desc     (lk_q)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_LO:  bus_rdata = desc_lo_word(stage_q);
            OFS_HI:  bus_rdata = desc_hi_word(stage_q);
            OFS_CMD: bus_rdata = {{(WORD_W-CMD_IDX_W){1'b0}}, last_idx};
            default: bus_rdata = '0;
        endcase
    end

    assign lk_base   = lk_q.base;
    assign lk_width  = lk_q.width;
    assign lk_height = lk_q.height;
    assign lk_wrap   = lk_q.wrap;
    assign lk_blk    = lk_q.blk;
    assign lk_endian = lk_q.endian;

endmodule

// File: rtl/sdt_checker.sv
module sdt_checker
    import surf_desc_pkg::*;
#(
    parameter bit HAS_ENDIAN = 1'b1,
    parameter int IDX_W      = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        cmd_bits,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [IDX_W-1:0]  lk_idx,
    input surf_desc_t        lk_desc,
    input logic              commit,
    input logic [IDX_W-1:0]  commit_idx,
    input surf_desc_t        stage,
    input logic              rb_load,
    input surf_desc_t        rb_desc
);

    AST_RST_LOOKUP_CLEAR: assert property (@(posedge clk)
        rst |=> (lk_desc == '0)); // R1

    AST_HI_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_HI) |-> (bus_rdata[31:30] == 2'b00)); // R3

    AST_CMD_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_CMD) |-> (bus_rdata[WORD_W-1:CMD_IDX_W] == '0)); // R4

    AST_COMMIT_SEEN: assert property (@(posedge clk) disable iff (rst)
        ($past(commit) && (lk_idx == $past(commit_idx)))
            |=> (lk_desc == $past(stage, 2))); // R4

    AST_FETCH_LANDS: assert property (@(posedge clk) disable iff (rst)
        rb_load |=> (stage == $past(rb_desc))); // R5

    AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFS_CMD) && (cmd_bits == 2'b11)) |=> !rb_load); // R6

    AST_ENDIAN_ABSENT: assert property (@(posedge clk) disable iff (rst)
        !HAS_ENDIAN |-> ((lk_desc.endian == '0) && (stage.endian == '0))); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr != OFS_LO) && (bus_addr != OFS_HI) && (bus_addr != OFS_CMD))
            |-> (bus_rdata == '0)); // R10

endmodule

bind surf_desc_table sdt_checker #(
    .HAS_ENDIAN (HAS_ENDIAN),
    .IDX_W      (IDX_W)
) u_sdt_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .cmd_bits   (bus_wdata[9:8]),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .lk_idx     (lk_idx),
    .lk_desc    (lk_q),
    .commit     (commit),
    .commit_idx (commit_idx),
    .stage      (stage_q),
    .rb_load    (rb_load),
    .rb_desc    (rb_desc)
);

// File: tb/surf_desc_table_test.sv
module surf_desc_table_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [7:0]  lk_idx;

    logic [31:0] rd_a, rd_b;
    logic [28:0] base_a, base_b;
    logic [11:0] wid_a, wid_b;
    logic [12:0] hgt_a, hgt_b;
    logic [1:0]  wrap_a, wrap_b, blk_a, blk_b;
    logic [3:0]  end_a, end_b;

    int checks = 0;
    int errors = 0;

    // Reference model: index 0 = endianness kept, index 1 = endianness dropped.
    logic [31:0] m_lo [2][256];
    logic [31:0] m_hi [2][256];
    logic [31:0] s_lo [2];
    logic [31:0] s_hi [2];
    logic [31:0] e_lo [2];
    logic [31:0] e_hi [2];
    logic        pend;
    logic [7:0]  pend_idx;
    logic [7:0]  last_idx;

    always #(PERIOD/2) clk = ~clk;

    surf_desc_table #(.NUM_ENTRIES(256), .HAS_ENDIAN(1'b1)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rd_a), .lk_idx(lk_idx),
        .lk_base(base_a), .lk_width(wid_a), .lk_height(hgt_a),
        .lk_wrap(wrap_a), .lk_blk(blk_a), .lk_endian(end_a)
    );

    surf_desc_table #(.NUM_ENTRIES(256), .HAS_ENDIAN(1'b0)) uut_ne (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rd_b), .lk_idx(lk_idx),
        .lk_base(base_b), .lk_width(wid_b), .lk_height(hgt_b),
        .lk_wrap(wrap_b), .lk_blk(blk_b), .lk_endian(end_b)
    );

    function automatic logic [31:0] hi_mask(input int v);
        return (v == 0) ? 32'h3FFF_FFFF : 32'h03FF_FFFF;
    endfunction

    function automatic logic [31:0] exp_rdata(input int v, input logic [3:0] a);
        case (a)
            4'h0:    return s_lo[v];
            4'h4:    return s_hi[v];
            4'h8:    return {24'h0, last_idx};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input logic we, input logic [3:0] a,
                              input logic [31:0] d, input logic [7:0] li);
        for (int v = 0; v < 2; v++) begin
            logic [31:0] f_lo, f_hi;
            f_lo = m_lo[v][pend_idx];
            f_hi = m_hi[v][pend_idx];
            e_lo[v] = m_lo[v][li];
            e_hi[v] = m_hi[v][li];
            if (we && a == 4'h8 && d[9]) begin
                m_lo[v][d[7:0]] = s_lo[v];
                m_hi[v][d[7:0]] = s_hi[v];
            end
            if (we && a == 4'h0) s_lo[v] = d;
            if (we && a == 4'h4) s_hi[v] = d & hi_mask(v);
            if (pend) begin
                s_lo[v] = f_lo;
                s_hi[v] = f_hi;
            end
        end
        if (we && a == 4'h8) last_idx = d[7:0];
        pend = we && (a == 4'h8) && d[8] && !d[9];
        if (pend) pend_idx = d[7:0];
    endtask

    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic [7:0] li, input string tag);
        bus_we = we;
        bus_addr = a;
        bus_wdata = d;
        lk_idx = li;
        #(PERIOD/4);
        check(tag, "rdata", rd_a, exp_rdata(0, a));
        check(tag, "rdata(no endian)", rd_b, exp_rdata(1, a));
        @(posedge clk);
        model_step(we, a, d, li);
        @(negedge clk);
        check(tag, "lookup lo", {wid_a[2:0], base_a}, e_lo[0]);
        check(tag, "lookup hi", {2'b00, end_a, blk_a, wrap_a, hgt_a, wid_a[11:3]}, e_hi[0]);
        check(tag, "lookup lo(no endian)", {wid_b[2:0], base_b}, e_lo[1]);
        check(tag, "lookup hi(no endian)", {2'b00, end_b, blk_b, wrap_b, hgt_b, wid_b[11:3]}, e_hi[1]);
    endtask

    function automatic logic [7:0] pick_idx();
        case ($urandom % 4)
            0:       return 8'd0;
            1:       return 8'd255;
            2:       return 8'd3;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int v = 0; v < 2; v++) begin
            for (int i = 0; i < 256; i++) begin
                m_lo[v][i] = '0;
                m_hi[v][i] = '0;
            end
            s_lo[v] = '0; s_hi[v] = '0; e_lo[v] = '0; e_hi[v] = '0;
        end
        pend = 1'b0; pend_idx = '0; last_idx = '0;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; lk_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything clear after reset
        cyc(1'b0, 4'h0, 32'h0, 8'd0,   "R1");
        cyc(1'b0, 4'h4, 32'h0, 8'd255, "R1");
        cyc(1'b0, 4'h8, 32'h0, 8'd128, "R1");

        // R2: low word load and readback
        cyc(1'b1, 4'h0, 32'hDEAD_BEEF, 8'd0, "R2");
        cyc(1'b0, 4'h0, 32'h0, 8'd0, "R2");

        // R3 / R9: high word, reserved bits and endianness variant
        cyc(1'b1, 4'h4, 32'hFFFF_FFFF, 8'd0, "R3");
        cyc(1'b0, 4'h4, 32'h0, 8'd0, "R3");
        cyc(1'b0, 4'h4, 32'h0, 8'd0, "R9");

        // R4: commit to entry 5, lookup the next cycle, command readback
        cyc(1'b1, 4'h8, 32'h0000_0205, 8'd0, "R4");
        cyc(1'b0, 4'h8, 32'h0, 8'd5, "R4");
        cyc(1'b0, 4'h4, 32'h0, 8'd5, "R9");

        // R8: commit and lookup of the same index in one cycle
        cyc(1'b1, 4'h0, 32'h1234_5678, 8'd0, "R8");
        cyc(1'b1, 4'h8, 32'h0000_0207, 8'd7, "R8");
        cyc(1'b0, 4'h0, 32'h0, 8'd7, "R8");

        // R5: fetch lands one edge after the command edge
        cyc(1'b1, 4'h0, 32'h0, 8'd0, "R5");
        cyc(1'b1, 4'h4, 32'h0, 8'd0, "R5");
        cyc(1'b1, 4'h8, 32'h0000_0105, 8'd0, "R5");
        cyc(1'b0, 4'h0, 32'h0, 8'd0, "R5");
        cyc(1'b0, 4'h0, 32'h0, 8'd0, "R5");
        cyc(1'b0, 4'h4, 32'h0, 8'd0, "R5");

        // R7: a landing fetch beats a bus write to staging
        cyc(1'b1, 4'h8, 32'h0000_0107, 8'd0, "R7");
        cyc(1'b1, 4'h0, 32'hAAAA_5555, 8'd0, "R7");
        cyc(1'b0, 4'h0, 32'h0, 8'd0, "R7");

        // R6: both enables set, commit only
        cyc(1'b1, 4'h0, 32'h0000_0F0F, 8'd0, "R6");
        cyc(1'b1, 4'h8, 32'h0000_030A, 8'd0, "R6");
        cyc(1'b1, 4'h0, 32'h0000_1111, 8'd10, "R6");
        cyc(1'b0, 4'h0, 32'h0, 8'd10, "R6");

        // R10: unmapped offsets
        cyc(1'b1, 4'hC, 32'hFFFF_FFFF, 8'd0, "R10");
        cyc(1'b0, 4'hC, 32'h0, 8'd0, "R10");
        cyc(1'b1, 4'h2, 32'hFFFF_FFFF, 8'd0, "R10");
        cyc(1'b0, 4'h0, 32'h0, 8'd0, "R10");

        // R4: boundary indices
        cyc(1'b1, 4'h4, 32'h2ABC_DEF1, 8'd0, "R4");
        cyc(1'b1, 4'h8, 32'h0000_02FF, 8'd0, "R4");
        cyc(1'b1, 4'h8, 32'hFFFF_FE00, 8'd255, "R4");
        cyc(1'b0, 4'h8, 32'h0, 8'd0, "R4");

        // R8: mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] ix;
            ix = pick_idx();
            case ($urandom % 7)
                0: cyc(1'b1, 4'h0, $urandom, pick_idx(), "R8");
                1: cyc(1'b1, 4'h4, $urandom, pick_idx(), "R8");
                2: cyc(1'b1, 4'h8, ($urandom & 32'hFFFF_FC00) | 32'h200 | {24'h0, ix}, pick_idx(), "R8");
                3: cyc(1'b1, 4'h8, 32'h100 | {24'h0, ix}, pick_idx(), "R8");
                4: cyc(1'b1, 4'h8, 32'h300 | {24'h0, ix}, pick_idx(), "R8");
                5: cyc(1'b1, 4'hC, $urandom, pick_idx(), "R10");
                default: cyc(1'b0, 4'($urandom), 32'h0, pick_idx(), "R8");
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule